// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block sits between a simple single-word request port and a synchronous DRAM. Each accepted request names a bank, a row, a column and, for writes, a data word with a per-byte mask. The sequencer handles each request in three steps. It opens the row with ACTIVE, issues one READ or WRITE, and then closes that bank with a single-bank PRECHARGE. Because every access closes its row, all banks are idle between requests. Power-up initialization is assumed to be finished before reset is released.

All SDRAM-side outputs are registered. Spacing between commands is counted in clock cycles. The default parameters suit a 100 MHz clock: row-to-column 2, active-to-precharge 5, precharge period 2, active-to-active 7, refresh cycle 7, write recovery 2. A free-running interval counter raises a refresh request about every 780 cycles. A pending refresh is served as soon as the access in flight has finished, and it blocks new requests until it has been issued. Read data is sampled from the DRAM data input after the programmed CAS latency. It is returned with a one-cycle valid strobe.

Top module: `sdramCmdSeq`

## Requirements
- R1: The command on {sdCsN,sdRasN,sdCasN,sdWeN} is one of the following, and no other code appears:
  - NOP = 0111 (whenever nothing is issued)
  - ACTIVE = 0011
  - READ = 0101
  - WRITE = 0100
  - PRECHARGE = 0010
  - AUTO REFRESH = 0001
- R2: An accepted request produces ACTIVE, then READ or WRITE, then PRECHARGE, in that order.
  - ACTIVE carries the request bank on sdBa and the row on sdAddr.
  - READ or WRITE carries the same bank, with the column on sdAddr[8:0] and sdAddr[10] low (no auto precharge).
  - PRECHARGE carries the same bank with sdAddr[10] low (single bank).
- R3: READ or WRITE appears at least T_RCD (2) cycles after the ACTIVE of the same access.
- R4: PRECHARGE appears at least T_RAS (5) cycles after ACTIVE, and at least T_WR (2) cycles after a WRITE.
- R5: Spacing before ACTIVE or AUTO REFRESH:
  - at least T_RP (2) cycles after a PRECHARGE;
  - at least T_RC (7) cycles after an ACTIVE;
  - at least T_RFC (7) cycles after an AUTO REFRESH.
- R6: In the WRITE cycle, sdDqOe is 1, sdDqOut holds the write data, and sdDqm equals the byte mask. A mask bit of 1 suppresses that byte. In every other cycle, sdDqOe and sdDqm are 0.
- R7: If READ is on the pins in cycle k, rdValid pulses for one cycle in cycle k+CAS_LAT+1. rdData then holds the value sdDqIn had at the end of cycle k+CAS_LAT.
- R8: With no requests, AUTO REFRESH appears exactly every REF_INTERVAL cycles.
- R9: A pending refresh is issued before any new ACTIVE, no later than the end of the access in flight. Under a continuous request stream, two refreshes are never more than REF_INTERVAL+8 cycles apart.
- R10: A request is taken when reqValid and reqReady are both high at a clock edge. Every accepted request yields exactly one ACTIVE. reqReady is low in the cycle after an acceptance.
- R11: During and right after reset:
  - the command is NOP;
  - sdDqOe and rdValid are 0;
  - reqReady is 1 in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | DATA_W/8 | Byte mask for writes, 1 = keep old byte |
| rdValid | output | 1 | Read data strobe |
| rdData | output | DATA_W | Read data |
| sdCsN | output | 1 | Chip select, low active |
| sdRasN | output | 1 | Row strobe, low active |
| sdCasN | output | 1 | Column strobe, low active |
| sdWeN | output | 1 | Write enable, low active |
| sdBa | output | BANK_W | Bank address |
| sdAddr | output | ROW_W | Row / column address, bit 10 = precharge scope |
| sdDqm | output | DATA_W/8 | Byte mask to DRAM |
| sdDqOut | output | DATA_W | Data to DRAM |
| sdDqOe | output | 1 | Drive enable for sdDqOut |
| sdDqIn | input | DATA_W | Data from DRAM |

## Verification
A wrong spacing counter shows at the pins as a command that comes too early. The bench's DRAM model catches this in the same cycle the command appears, measured against the previous ACTIVE, PRECHARGE, WRITE or AUTO REFRESH. A read pipeline that is off by one stage makes rdValid fire a cycle early or late. The model only drives valid data for one cycle, so rdData would then hold the filler pattern, and the read vector fails straight away. A broken refresh path shows up as a refresh gap different from REF_INTERVAL when idle, or too long under streaming load, within one interval. A lost or duplicated request shows up as a mismatch between accepted handshakes and ACTIVE commands.

// File: rtl/sdramSeqPkg.sv
package sdramSeqPkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdCmdE;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic issueAct;
    logic issueRw;
    logic issuePre;
    logic issueRef;
    logic latchReq;
  } seqStrobeT;

endpackage

// File: rtl/sdramSeqCtrl.sv
module sdramSeqCtrl
  import sdramSeqPkg::*;
#(
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_RFC        = 7,
  parameter int T_WR         = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output seqStrobeT strobe
);

  localparam int CNT_W = $clog2(T_RCD + T_RAS + T_RP + T_RC + T_RFC + T_WR + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);
  localparam int REF_WAIT_MAX = 2 * (T_RC + T_RAS + T_WR + T_RP + T_RFC);

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_CLOSE} stateE;

  stateE            state, stateNext;
  logic [CNT_W-1:0] gapCnt, gapNext;    // blocks ACTIVE / REFRESH
  logic [CNT_W-1:0] stepCnt, stepNext;  // per-step wait inside an access
  logic [CNT_W-1:0] rasCnt, rasNext;    // active-to-precharge
  logic [REF_W-1:0] refCnt;
  logic             refPending, refPendNext;
  logic             curWrite;

  function automatic logic [CNT_W-1:0] decSat(input logic [CNT_W-1:0] v);
    return (v != '0) ? v - 1'b1 : '0;
  endfunction

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    gapNext     = decSat(gapCnt);
    stepNext    = decSat(stepCnt);
    rasNext     = decSat(rasCnt);
    refPendNext = refPending;
    reqReady    = (state == ST_IDLE) && (gapCnt == '0) && !refPending;

    unique case (state)
      ST_IDLE: begin
        if (refPending && gapCnt == '0) begin
          strobe.issueRef = 1'b1;
          gapNext         = CNT_W'(T_RFC - 1);
          refPendNext     = 1'b0;
        end else if (reqReady && reqValid) begin
          strobe.issueAct = 1'b1;
          strobe.latchReq = 1'b1;
          gapNext         = CNT_W'(T_RC - 1);
          rasNext         = CNT_W'(T_RAS - 1);
          stepNext        = CNT_W'(T_RCD - 1);
          stateNext       = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (stepCnt == '0) begin
          strobe.issueRw = 1'b1;
          stepNext       = curWrite ? CNT_W'(T_WR - 1) : '0;
          stateNext      = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if (stepCnt == '0 && rasCnt == '0) begin
          strobe.issuePre = 1'b1;
          if (gapNext < CNT_W'(T_RP - 1)) gapNext = CNT_W'(T_RP - 1);
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase

    if (refCnt == REF_W'(REF_INTERVAL - 1)) refPendNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      gapCnt     <= '0;
      stepCnt    <= '0;
      rasCnt     <= '0;
      refCnt     <= '0;
      refPending <= 1'b0;
      curWrite   <= 1'b0;
    end else begin
      state      <= stateNext;
      gapCnt     <= gapNext;
      stepCnt    <= stepNext;
      rasCnt     <= rasNext;
      refPending <= refPendNext;
      refCnt     <= (refCnt == REF_W'(REF_INTERVAL - 1)) ? '0 : refCnt + 1'b1;
      if (strobe.latchReq) curWrite <= reqWrite;
    end
  end

  // Checks
  logic [7:0] refWait;
  always_ff @(posedge clk) begin
    if (!rstN)           refWait <= '0;
    else if (!refPending) refWait <= '0;
    else if (refWait != 8'hFF) refWait <= refWait + 1'b1;
  end

  a_r9_refresh_before_active: assert property (@(posedge clk) disable iff (!rstN)
    refPending |-> !strobe.issueAct);

  a_r9_refresh_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    refWait <= 8'(REF_WAIT_MAX));

  a_r10_ready_drops_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchReq |=> !reqReady);

endmodule

// File: rtl/sdramSeqData.sv
module sdramSeqData
  import sdramSeqPkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2,
  parameter int T_RCD   = 2,
  parameter int T_RAS   = 5,
  parameter int T_RP    = 2,
  parameter int T_RC    = 7,
  parameter int T_RFC   = 7,
  parameter int T_WR    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobeT              strobe,
  input  logic                   reqWrite,
  input  logic [BANK_W-1:0]      reqBank,
  input  logic [ROW_W-1:0]       reqRow,
  input  logic [COL_W-1:0]       reqCol,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqMask,
  output logic                   sdCsN,
  output logic                   sdRasN,
  output logic                   sdCasN,
  output logic                   sdWeN,
  output logic [BANK_W-1:0]      sdBa,
  output logic [ROW_W-1:0]       sdAddr,
  output logic [DATA_W/8-1:0]    sdDqm,
  output logic [DATA_W-1:0]      sdDqOut,
  output logic                   sdDqOe,
  input  logic [DATA_W-1:0]      sdDqIn,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData
);

  localparam int MASK_W  = DATA_W / 8;
  localparam int AGE_MAX = T_RC + T_RFC + T_RAS;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  // Latched request
  logic [BANK_W-1:0] bankQ;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] wdataQ;
  logic [MASK_W-1:0] maskQ;
  logic              writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= '0;
      colQ   <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
      writeQ <= 1'b0;
    end else if (strobe.latchReq) begin
      bankQ  <= reqBank;
      colQ   <= reqCol;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
      writeQ <= reqWrite;
    end
  end

  // Registered command bus
  sdCmdE             cmdQ;
  logic [BANK_W-1:0] baQ;
  logic [ROW_W-1:0]  addrQ;
  logic [MASK_W-1:0] dqmQ;
  logic [DATA_W-1:0] dqOutQ;
  logic              dqOeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= CMD_NOP;
      baQ    <= '0;
      addrQ  <= '0;
      dqmQ   <= '0;
      dqOutQ <= '0;
      dqOeQ  <= 1'b0;
    end else begin
      cmdQ   <= CMD_NOP;
      baQ    <= '0;
      addrQ  <= '0;
      dqmQ   <= '0;
      dqOeQ  <= 1'b0;
      if (strobe.issueAct) begin
        cmdQ  <= CMD_ACT;
        baQ   <= reqBank;
        addrQ <= reqRow;
      end else if (strobe.issueRw) begin
        cmdQ  <= writeQ ? CMD_WR : CMD_RD;
        baQ   <= bankQ;
        addrQ <= ROW_W'(colQ);   // bit 10 stays low: no auto precharge
        if (writeQ) begin
          dqOutQ <= wdataQ;
          dqOeQ  <= 1'b1;
          dqmQ   <= maskQ;
        end
      end else if (strobe.issuePre) begin
        cmdQ <= CMD_PRE;         // bit 10 low: this bank only
        baQ  <= bankQ;
      end else if (strobe.issueRef) begin
        cmdQ <= CMD_REF;
      end
    end
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;
  assign sdBa    = baQ;
  assign sdAddr  = addrQ;
  assign sdDqm   = dqmQ;
  assign sdDqOut = dqOutQ;
  assign sdDqOe  = dqOeQ;

  // Read capture: stage 0 is the cycle READ is on the pins.
  logic [CAS_LAT:0] rdPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPipe  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdPipe  <= {rdPipe[CAS_LAT-1:0], strobe.issueRw & ~writeQ};
      rdValid <= rdPipe[CAS_LAT];
      if (rdPipe[CAS_LAT]) rdData <= sdDqIn;
    end
  end

  // Spacing monitors on the pin-level command
  logic [AGE_W-1:0] actAge, preAge, refAge, wrAge;

  function automatic logic [AGE_W-1:0] ageStep(input logic hit, input logic [AGE_W-1:0] v);
    if (hit) return AGE_W'(1);
    return (v == AGE_W'(AGE_MAX)) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actAge <= AGE_W'(AGE_MAX);
      preAge <= AGE_W'(AGE_MAX);
      refAge <= AGE_W'(AGE_MAX);
      wrAge  <= AGE_W'(AGE_MAX);
    end else begin
      actAge <= ageStep(cmdQ == CMD_ACT, actAge);
      preAge <= ageStep(cmdQ == CMD_PRE, preAge);
      refAge <= ageStep(cmdQ == CMD_REF, refAge);
      wrAge  <= ageStep(cmdQ == CMD_WR,  wrAge);
    end
  end

  a_r1_one_command: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issueAct, strobe.issueRw, strobe.issuePre, strobe.issueRef}));

  a_r3_row_to_column: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_RD || cmdQ == CMD_WR) |-> actAge >= AGE_W'(T_RCD));

  a_r4_close_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_PRE) |-> (actAge >= AGE_W'(T_RAS) && wrAge >= AGE_W'(T_WR)));

  a_r5_open_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT || cmdQ == CMD_REF) |->
      (actAge >= AGE_W'(T_RC) && preAge >= AGE_W'(T_RP) && refAge >= AGE_W'(T_RFC)));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/sdramCmdSeq.sv
module sdramCmdSeq
  import sdramSeqPkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int CAS_LAT      = 2,
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_RFC        = 7,
  parameter int T_WR         = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [ROW_W-1:0]    reqRow,
  input  logic [COL_W-1:0]    reqCol,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                sdCsN,
  output logic                sdRasN,
  output logic                sdCasN,
  output logic                sdWeN,
  output logic [BANK_W-1:0]   sdBa,
  output logic [ROW_W-1:0]    sdAddr,
  output logic [DATA_W/8-1:0] sdDqm,
  output logic [DATA_W-1:0]   sdDqOut,
  output logic                sdDqOe,
  input  logic [DATA_W-1:0]   sdDqIn
);

  seqStrobeT strobe;

  sdramSeqCtrl #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC),
    .T_RFC(T_RFC), .T_WR(T_WR), .REF_INTERVAL(REF_INTERVAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdramSeqData #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_RFC(T_RFC), .T_WR(T_WR)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .reqMask(reqMask),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut),
    .sdDqOe(sdDqOe), .sdDqIn(sdDqIn), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/tb_sdramCmdSeq.sv
module tb_sdramCmdSeq;

  localparam int CL     = 3;
  localparam int REFINT = 100;
  localparam int NVEC   = 12;
  localparam logic [15:0] JUNK = 16'hDEAD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [8:0]  reqCol = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rdValid, sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [15:0] rdData, sdDqOut;
  logic [15:0] sdDqIn = JUNK;
  logic [1:0]  sdBa, sdDqm;
  logic [12:0] sdAddr;

  sdramCmdSeq #(.CAS_LAT(CL), .REF_INTERVAL(REFINT)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .reqMask(reqMask), .rdValid(rdValid), .rdData(rdData),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut),
    .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  // Vectors: write flag, bank, row, column, data, mask, expected read
  localparam logic        V_WR   [NVEC] = '{1, 1, 1, 1, 0, 0, 0, 1, 0, 1, 0, 0};
  localparam logic [1:0]  V_BANK [NVEC] = '{0, 1, 0, 0, 0, 1, 0, 3, 3, 1, 1, 2};
  localparam logic [12:0] V_ROW  [NVEC] = '{13'h0010, 13'h1FFF, 13'h0010, 13'h0010,
                                            13'h0010, 13'h1FFF, 13'h0010, 13'h0ABC,
                                            13'h0ABC, 13'h1FFF, 13'h1FFF, 13'h0000};
  localparam logic [8:0]  V_COL  [NVEC] = '{9'h005, 9'h1FF, 9'h006, 9'h005, 9'h005, 9'h1FF,
                                            9'h006, 9'h100, 9'h100, 9'h1FF, 9'h1FF, 9'h000};
  localparam logic [15:0] V_DATA [NVEC] = '{16'h1234, 16'hABCD, 16'h5555, 16'hFFEE, 16'h0,
                                            16'h0, 16'h0, 16'h0F0F, 16'h0, 16'h9876, 16'h0, 16'h0};
  localparam logic [1:0]  V_MASK [NVEC] = '{0, 0, 0, 1, 0, 0, 0, 2, 0, 3, 0, 0};
  localparam logic [15:0] V_EXP  [NVEC] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'hFF34, 16'hABCD,
                                            16'h5555, 16'h0, 16'h000F, 16'h0, 16'hABCD, 16'h0000};

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // DRAM model and pin-level protocol checker
  logic [15:0] mem [int];
  bit   openB [4];
  int   openRow [4];
  int   lastAct = -100, lastPre = -100, lastRef = -100, prevRef = -100, lastWr = -100;
  int   lastRd = -100, actCount = 0, refCount = 0, rdCount = 0, maxRefGap = 0;
  int   pend = 0;
  logic [15:0] rdMem;
  logic [3:0]  cmd;

  function automatic int keyOf(input logic [1:0] b, input int r, input logic [8:0] c);
    return (int'(b) << 22) | (r << 9) | int'(c);
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (pend > 0) begin
        pend--;
        sdDqIn = (pend == 0) ? rdMem : JUNK;
      end else sdDqIn = JUNK;

      if (rdValid) begin
        rdCount++;
        check(cyc == lastRd + CL + 1, "R7 read strobe cycle", cyc, lastRd + CL + 1);
      end

      cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
      if (cmd != 4'b0100)
        check(!sdDqOe && sdDqm == 2'b00, "R6 idle data pins", {sdDqOe, sdDqm}, 0);
      case (cmd)
        4'b0111: ;
        4'b0011: begin
          check(sdBa == reqBank && sdAddr == reqRow, "R2 active bank/row",
                {sdBa, sdAddr}, {reqBank, reqRow});
          check(!openB[sdBa], "R2 bank already open", 1, 0);
          check(cyc - lastAct >= 7 && cyc - lastPre >= 2 && cyc - lastRef >= 7,
                "R5 active spacing", cyc, 0);
          openB[sdBa] = 1; openRow[sdBa] = int'(sdAddr);
          lastAct = cyc; actCount++;
        end
        4'b0101, 4'b0100: begin
          check(openB[sdBa] && sdBa == reqBank && sdAddr[8:0] == reqCol && !sdAddr[10],
                "R2 column command", {sdBa, sdAddr}, {reqBank, 4'b0, reqCol});
          check(cyc - lastAct >= 2, "R3 row to column", cyc - lastAct, 2);
          if (cmd == 4'b0101) begin
            rdMem = mem.exists(keyOf(sdBa, openRow[sdBa], sdAddr[8:0])) ?
                    mem[keyOf(sdBa, openRow[sdBa], sdAddr[8:0])] : 16'h0000;
            pend = CL; lastRd = cyc;
          end else begin
            check(sdDqOe && sdDqOut == reqWdata && sdDqm == reqMask, "R6 write data pins",
                  {sdDqOe, sdDqm, sdDqOut}, {1'b1, reqMask, reqWdata});
            begin
              logic [15:0] v;
              v = mem.exists(keyOf(sdBa, openRow[sdBa], sdAddr[8:0])) ?
                  mem[keyOf(sdBa, openRow[sdBa], sdAddr[8:0])] : 16'h0000;
              for (int b = 0; b < 2; b++) if (!sdDqm[b]) v[b*8 +: 8] = sdDqOut[b*8 +: 8];
              mem[keyOf(sdBa, openRow[sdBa], sdAddr[8:0])] = v;
            end
            lastWr = cyc;
          end
        end
        4'b0010: begin
          check(openB[sdBa] && !sdAddr[10], "R2 single-bank close", {sdBa, sdAddr}, 0);
          check(cyc - lastAct >= 5 && cyc - lastWr >= 2, "R4 close spacing", cyc, 0);
          openB[sdBa] = 0; lastPre = cyc;
        end
        4'b0001: begin
          check(!(openB[0] | openB[1] | openB[2] | openB[3]), "R5 refresh with open row", 1, 0);
          check(cyc - lastAct >= 7 && cyc - lastPre >= 2 && cyc - lastRef >= 7,
                "R5 refresh spacing", cyc, 0);
          prevRef = lastRef; lastRef = cyc; refCount++;
          if (prevRef >= 0 && cyc - prevRef > maxRefGap) maxRefGap = cyc - prevRef;
        end
        default: check(0, "R1 illegal command code", cmd, 4'b0111);
      endcase
    end
  end

  task automatic doAccess(input int i);
    int w;
    w = 0;
    @(negedge clk);
    while (!reqReady && w < 100) begin @(negedge clk); w++; end
    reqWrite = V_WR[i]; reqBank = V_BANK[i]; reqRow = V_ROW[i]; reqCol = V_COL[i];
    reqWdata = V_DATA[i]; reqMask = V_MASK[i]; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R10 ready low after accept", reqReady, 0);
    if (!V_WR[i]) begin
      w = 0;
      while (!rdValid && w < 30) begin @(negedge clk); w++; end
      check(rdValid && rdData == V_EXP[i], "R7 read data", rdData, V_EXP[i]);
    end
  endtask

  initial begin
    int rc0, acc0, act0, rd0, ref0, accepts, w;
    repeat (3) @(negedge clk);
    check({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0111, "R11 reset command",
          {sdCsN, sdRasN, sdCasN, sdWeN}, 4'b0111);
    check(!sdDqOe && !rdValid, "R11 reset outputs", {sdDqOe, rdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R11 ready after reset", reqReady, 1);

    // vector walk: writes, masked writes, reads, boundary row/column
    for (int i = 0; i < NVEC; i++) doAccess(i);

    // R8: idle refresh cadence
    repeat (10) @(negedge clk);
    rc0 = refCount; w = 0;
    while (refCount < rc0 + 3 && w < 5 * REFINT) begin @(negedge clk); w++; end
    check(lastRef - prevRef == REFINT, "R8 idle refresh period", lastRef - prevRef, REFINT);

    // R9 / R10: continuous stream of reads
    reqWrite = 1'b0; reqBank = 2'd0; reqRow = 13'h0010; reqCol = 9'h005;
    reqMask = 2'b00; maxRefGap = 0;
    act0 = actCount; rd0 = rdCount; ref0 = refCount; accepts = 0;
    @(negedge clk);
    reqValid = 1'b1;
    for (int c = 0; c < 4 * REFINT; c++) begin
      if (reqReady) accepts++;
      @(negedge clk);
      if (rdValid) check(rdData == 16'hFF34, "R7 streamed read data", rdData, 16'hFF34);
    end
    reqValid = 1'b0;
    repeat (30) @(negedge clk);
    check(refCount - ref0 >= 3, "R9 refresh served under load", refCount - ref0, 3);
    check(maxRefGap <= REFINT + 8, "R9 refresh gap under load", maxRefGap, REFINT + 8);
    check(actCount - act0 == accepts, "R10 one active per accept", actCount - act0, accepts);
    check(rdCount - rd0 == accepts, "R7 one strobe per read", rdCount - rd0, accepts);
    check(accepts > 20, "R10 stream throughput", accepts, 20);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule